// File: doc/BRIEF.md
# Channel Idle Timer

This block measures how long a DMA channel has gone without activity. A free-running tick-enable sets the time base. While the timer is running and out of reset, each tick advances a 16-bit count. When the count reaches a programmed limit, the block emits a one-cycle interrupt pulse. That pulse is placed on the timer position of the channel's status-set vector, so the channel status register can latch it.

Software controls the timer through one 32-bit control word. The word holds a software reset bit (active low), a run bit, a mode bit and the 16-bit limit. In one-shot mode the timer expires once and then waits for a software reset. In periodic mode it wraps to zero and keeps going. A pulse on the activity input returns the count to zero and raises no interrupt. The current count can be read at any time.

Top module: `idle_tmr`

## Requirements
- R1: The control word uses bit 31 as the timer reset (active low), bit 30 as run, bit 29 as mode (0 one-shot, 1 periodic) and bits 15:0 as the limit. A write takes effect from the clock edge that accepts it. After hardware reset the word is all zeros, so the timer is held in reset and not running.
- R2: While the reset bit is 0, the count is 0 and no interrupt is raised. Writing 0 and then 1 to bit 31 restarts the timer from zero and clears a one-shot expiry.
- R3: The count rises by exactly one on each clock where tick_en is 1, run is 1 and the reset bit is 1. In every other case it holds its value.
- R4: cnt_word carries the current count in bits 15:0 and zeros in bits 31:16.
- R5: When a counting tick brings the count to a nonzero limit, stat_set bit 1 is 1 for exactly the following clock. All other stat_set bits are always 0.
- R6: In one-shot mode, after expiry the count stays at the limit. No further pulse occurs, and neither ticks nor activity change the count, until the reset sequence of R2.
- R7: In periodic mode, expiry returns the count to 0 and counting continues, so with steady ticks a pulse appears once every limit ticks (every tick for a limit of 1).
- R8: chan_active set to 1 while the timer is out of reset and not expired clears the count to 0 at the next edge without a pulse. It takes priority over a tick in the same cycle.
- R9: A limit of 0 never raises a pulse. The count then runs on and wraps from 65535 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hardware reset, active low, asynchronous |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 32 | Control word write data |
| tick_en | input | 1 | Time-base tick enable |
| chan_active | input | 1 | Channel activity pulse, restarts the count |
| cnt_word | output | 32 | Current count, zero-extended |
| stat_set | output | 6 | Status set pulses; bit 1 is the timer expiry |

## Verification
If the count register holds a wrong value, cnt_word shows it on the very next clock. A faulty expiry flag or a wrong mode decode only shows later: an extra pulse, a missing pulse, or a count that keeps moving on stat_set and cnt_word at the next limit crossing. The bench therefore compares both outputs against a behavioural model on every clock. It places its stimulus so that each expiry, hold, activity clear and wrap is followed by further ticks that would expose a corrupted state.

// File: rtl/idle_tmr_pkg.sv
package idle_tmr_pkg;

    typedef enum logic {
        TMR_ONESHOT  = 1'b0,
        TMR_PERIODIC = 1'b1
    } tmr_mode_e;

endpackage

// File: rtl/idle_tmr_cfg.sv
module idle_tmr_cfg
    import idle_tmr_pkg::*;
#(
    parameter int CTRL_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [CTRL_W-1:0] wdata_i,
    output logic              srst_n_o,
    output logic              run_o,
    output tmr_mode_e         mode_o,
    output logic [CNT_W-1:0]  thr_o
);
    localparam int RST_POS  = CTRL_W - 1;
    localparam int RUN_POS  = CTRL_W - 2;
    localparam int MODE_POS = CTRL_W - 3;

    typedef struct packed {
        logic             srst_n;
        logic             run;
        tmr_mode_e        mode;
        logic [CNT_W-1:0] thr;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (we_i) begin
            cfg_d.srst_n = wdata_i[RST_POS];
            cfg_d.run    = wdata_i[RUN_POS];
            cfg_d.mode   = tmr_mode_e'(wdata_i[MODE_POS]);
            cfg_d.thr    = wdata_i[CNT_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign srst_n_o = cfg_q.srst_n;
    assign run_o    = cfg_q.run;
    assign mode_o   = cfg_q.mode;
    assign thr_o    = cfg_q.thr;

    // R1
    wr_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(we_i) |-> (srst_n_o == $past(wdata_i[RST_POS])) && (thr_o == $past(wdata_i[CNT_W-1:0])));
endmodule

// File: rtl/idle_tmr_core.sv
module idle_tmr_core
    import idle_tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             srst_n_i,
    input  logic             run_i,
    input  tmr_mode_e        mode_i,
    input  logic [CNT_W-1:0] thr_i,
    input  logic             tick_i,
    input  logic             act_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             expire_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             done;
        logic             irq;
    } st_t;

    st_t st_d, st_q;
    logic [CNT_W-1:0] adv;

    always_comb begin
        st_d     = st_q;
        st_d.irq = 1'b0;
        adv      = st_q.cnt + 1'b1;
        if (!srst_n_i) begin
            st_d.cnt  = '0;
            st_d.done = 1'b0;
        end else if (st_q.done) begin
            st_d.cnt = st_q.cnt;
        end else if (act_i) begin
            st_d.cnt = '0;
        end else if (run_i && tick_i) begin
            if ((thr_i != '0) && (adv == thr_i)) begin
                st_d.irq = 1'b1;
                if (mode_i == TMR_PERIODIC) begin
                    st_d.cnt = '0;
                end else begin
                    st_d.cnt  = adv;
                    st_d.done = 1'b1;
                end
            end else begin
                st_d.cnt = adv;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_o    = st_q.cnt;
    assign expire_o = st_q.irq;

    // R2
    held_in_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!srst_n_i) |-> (cnt_o == '0) && !expire_o);
    // R5
    pulse_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        expire_o |-> $past(tick_i && run_i && srst_n_i && !act_i));
    // R6
    oneshot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(st_q.done && srst_n_i) |-> $stable(cnt_o) && !expire_o);
    // R8
    activity_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(act_i && srst_n_i && !st_q.done) |-> (cnt_o == '0) && !expire_o);
    // R9
    zero_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(thr_i == '0) |-> !expire_o);
endmodule

// File: rtl/idle_tmr_irqmap.sv
module idle_tmr_irqmap #(
    parameter int STAT_W  = 6,
    parameter int TMR_BIT = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              expire_i,
    output logic [STAT_W-1:0] stat_o
);
    for (genvar b = 0; b < STAT_W; b++) begin : g_bit
        if (b == TMR_BIT) begin : g_tmr
            assign stat_o[b] = expire_i;
        end else begin : g_other
            assign stat_o[b] = 1'b0;
        end
    end

    // R5
    stat_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(stat_o));
endmodule

// File: rtl/idle_tmr.sv
module idle_tmr
    import idle_tmr_pkg::*;
#(
    parameter int CTRL_W  = 32,
    parameter int CNT_W   = 16,
    parameter int STAT_W  = 6,
    parameter int TMR_BIT = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CTRL_W-1:0] cfg_wdata,
    input  logic              tick_en,
    input  logic              chan_active,
    output logic [CTRL_W-1:0] cnt_word,
    output logic [STAT_W-1:0] stat_set
);
    localparam int PAD_W = CTRL_W - CNT_W;

    logic             srst_n;
    logic             run;
    tmr_mode_e        mode;
    logic [CNT_W-1:0] thr;
    logic [CNT_W-1:0] cnt;
    logic             expire;

    idle_tmr_cfg #(.CTRL_W(CTRL_W), .CNT_W(CNT_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .we_i(cfg_we), .wdata_i(cfg_wdata),
        .srst_n_o(srst_n), .run_o(run), .mode_o(mode), .thr_o(thr)
    );

    idle_tmr_core #(.CNT_W(CNT_W)) u_core (
        .clk(clk), .rst_n(rst_n), .srst_n_i(srst_n), .run_i(run),
        .mode_i(mode), .thr_i(thr), .tick_i(tick_en), .act_i(chan_active),
        .cnt_o(cnt), .expire_o(expire)
    );

    idle_tmr_irqmap #(.STAT_W(STAT_W), .TMR_BIT(TMR_BIT)) u_map (
        .clk(clk), .rst_n(rst_n), .expire_i(expire), .stat_o(stat_set)
    );

    assign cnt_word = {{PAD_W{1'b0}}, cnt};
endmodule

// File: tb/idle_tmr_tb_top.sv
module idle_tmr_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic        tick_en = 1'b0;
    logic        chan_active = 1'b0;
    logic [31:0] cnt_word;
    logic [5:0]  stat_set;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    // model state
    int m_srst = 0, m_run = 0, m_mode = 0, m_thr = 0;
    int m_cnt = 0, m_done = 0, m_irq = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    idle_tmr dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .tick_en(tick_en), .chan_active(chan_active),
        .cnt_word(cnt_word), .stat_set(stat_set)
    );

    task automatic check(string tag);
        total++;
        if (cnt_word !== 32'(m_cnt)) begin
            bad++;
            $display("FAIL %s count: got %0d expected %0d", tag, cnt_word, m_cnt);
        end
        total++;
        if (stat_set !== (m_irq != 0 ? 6'b000010 : 6'b000000)) begin
            bad++;
            $display("FAIL %s status: got %b expected %b", tag, stat_set,
                     (m_irq != 0 ? 6'b000010 : 6'b000000));
        end
    endtask

    // one clock: check state after previous edge, drive, advance model
    task automatic step(string tag, bit we, logic [31:0] wd, bit tk, bit act);
        @(negedge clk);
        check(tag);
        cfg_we = we; cfg_wdata = wd; tick_en = tk; chan_active = act;
        m_irq = 0;
        if (m_srst == 0) begin
            m_cnt = 0; m_done = 0;
        end else if (m_done != 0) begin
        end else if (act) begin
            m_cnt = 0;
        end else if (m_run != 0 && tk) begin
            if (m_thr != 0 && ((m_cnt + 1) % 65536) == m_thr) begin
                m_irq = 1;
                if (m_mode != 0) m_cnt = 0;
                else begin m_cnt = m_thr; m_done = 1; end
            end else begin
                m_cnt = (m_cnt + 1) % 65536;
            end
        end
        if (we) begin
            m_srst = wd[31]; m_run = wd[30]; m_mode = wd[29]; m_thr = wd[15:0];
        end
    endtask

    function automatic logic [31:0] ctl(bit r, bit run, bit md, int thr);
        return {r, run, md, 13'd0, 16'(thr)};
    endfunction

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state, ticks ignored while held in reset
        step("R1", 0, '0, 1, 0);
        step("R1", 0, '0, 1, 0);
        // R2: ticks while reset bit low keep zero
        for (int i = 0; i < 3; i++) step("R2", 0, '0, 1, 0);
        // R1/R5/R6: one-shot, limit 5
        step("R1", 1, ctl(1, 1, 0, 5), 0, 0);
        for (int i = 0; i < 8; i++) step("R5", 0, '0, 1, 0);
        step("R6", 0, '0, 1, 1);
        step("R6", 0, '0, 0, 1);
        for (int i = 0; i < 3; i++) step("R6", 0, '0, 1, 0);
        // R2: reset sequence restarts, periodic limit 3, sparse ticks
        step("R2", 1, ctl(0, 1, 1, 3), 1, 0);
        step("R2", 1, ctl(1, 1, 1, 3), 1, 0);
        for (int i = 0; i < 20; i++) step("R7", 0, '0, (i % 3) != 1, 0);
        // R3: run off holds count
        step("R3", 1, ctl(1, 0, 1, 3), 1, 0);
        for (int i = 0; i < 5; i++) step("R3", 0, '0, 1, 0);
        step("R3", 1, ctl(1, 1, 1, 10), 0, 0);
        for (int i = 0; i < 4; i++) step("R3", 0, '0, (i % 2) == 0, 0);
        // R8: activity clears, wins over tick
        for (int i = 0; i < 5; i++) step("R8", 0, '0, 1, 0);
        step("R8", 0, '0, 1, 1);
        for (int i = 0; i < 9; i++) step("R8", 0, '0, 1, 0);
        step("R8", 0, '0, 1, 1);
        for (int i = 0; i < 12; i++) step("R8", 0, '0, 1, 0);
        // R7: limit 1 periodic pulses every tick
        step("R7", 1, ctl(1, 1, 1, 1), 0, 0);
        for (int i = 0; i < 6; i++) step("R7", 0, '0, 1, 0);
        // R9/R4: zero limit wraps, no pulse
        step("R9", 1, ctl(0, 0, 0, 0), 0, 0);
        step("R9", 1, ctl(1, 1, 0, 0), 0, 0);
        for (int i = 0; i < 65540; i++) step("R9", 0, '0, 1, 0);
        // R4: upper bits of count word are zero
        @(negedge clk);
        total++;
        if (cnt_word[31:16] !== 16'd0) begin
            bad++;
            $display("FAIL R4 upper bits: got %h expected 0", cnt_word[31:16]);
        end
        // R1: write with run and one-shot limit 2 after hardware reset again
        rst_n = 1'b0;
        m_srst = 0; m_run = 0; m_mode = 0; m_thr = 0; m_cnt = 0; m_done = 0; m_irq = 0;
        cfg_we = 0; tick_en = 0; chan_active = 0;
        @(negedge clk);
        rst_n = 1'b1;
        step("R1", 0, '0, 1, 0);
        step("R1", 1, ctl(1, 1, 0, 2), 1, 0);
        for (int i = 0; i < 5; i++) step("R6", 0, '0, 1, 0);
        step("R6", 0, '0, 0, 0);
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule